// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

One down-counting timer channel behind a small register interface. It can run as a plain periodic timer or drive a square wave whose low and high phases are set independently. In PWM mode the counter takes its value from one reload register for the low phase and from a second reload register for the high phase. The output flips each time the counter passes through zero. A phase lasts the register value plus one clocks, so the output can never sit at a constant level while the channel is running.

Software sets the two phase lengths, then enables the channel. The lengths are copied into the counter path at that moment, so later writes wait for the next enable. Each zero crossing sets a sticky interrupt flag. Software clears it by reading the end-of-interrupt location, and a mask bit hides it from the interrupt line. The register interface is a single-cycle read/write port with combinational read data.

Top module: `pwm_timer`

## Requirements
- R1: In PWM mode the low phase lasts (low_load + 1) clocks and the high phase lasts (high_load + 1) clocks, and the two phases keep alternating.
- R2: Both reload registers are 32 bits. Loading 0 into both gives one-clock phases, so the PWM output toggles every clock and 0 % and 100 % duty are not possible.
- R3: When the channel is enabled in PWM mode, the output starts in the low phase and rises exactly (low_load + 1) clocks after the enabling write.
- R4: While enabled in user mode (control bit 1 = 1), the counter falls by one each clock and reloads when it reaches 0. With PWM off (control bit 3 = 0) it always reloads low_load and pwm_o stays 0.
- R5: While disabled (control bit 0 = 0), the counter holds its value and pwm_o is 0.
- R6: In free-running mode (control bit 1 = 0), an enable loads 0xFFFFFFFF and every zero reloads 0xFFFFFFFF, whatever the reload registers hold.
- R7: The control register reads back as written in bits 3:0: bit 0 enable, bit 1 mode, bit 2 interrupt mask, bit 3 PWM. The current-count location ignores writes and returns the live counter.
- R8: Each zero reached while enabled sets a sticky flag, and a new zero wins over a clear in the same cycle. The status location returns flag AND NOT mask in bit 0, and irq_o carries the same value. A read of the end-of-interrupt location returns 0 and clears the flag.
- R9: A reload-register write while the channel is enabled leaves the phases in progress unchanged. The new values take effect at the next enable.
- R10: Register offsets: low_load 0x00, current count 0x04, control 0x08, end-of-interrupt 0x0C, status 0x10, high_load 0xB0 + 4·CH_IDX. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (only matters for end-of-interrupt) |
| addr_i | input | AW | Byte offset of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, same cycle |
| pwm_o | output | 1 | PWM output, low while disabled |
| irq_o | output | 1 | Masked interrupt flag |

## Verification
The main function is driven with asymmetric reloads (3/5), then with both reloads at zero, and then with reloads rewritten in mid-run followed by a re-enable. The asymmetric case separates the two phase registers and exposes off-by-one errors in the first phase after enable. The zero case shows that no phase collapses. The rewrite case tells a snapshot taken at enable apart from live use of the shadow registers. Free-running and user non-PWM runs are compared by reading the live count, and a behavioural model checks pwm_o and irq_o on every clock. The interrupt is tried unmasked, masked, cleared while idle, and unmasked while the flag is already pending.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef struct packed {
    logic pwm_on;     // bit 3
    logic irq_mask;   // bit 2
    logic user_mode;  // bit 1
    logic enable;     // bit 0
  } tmr_ctrl_t;

  localparam int unsigned OFS_LOAD_LO = 32'h00;
  localparam int unsigned OFS_CUR     = 32'h04;
  localparam int unsigned OFS_CTRL    = 32'h08;
  localparam int unsigned OFS_EOI     = 32'h0C;
  localparam int unsigned OFS_STAT    = 32'h10;
  localparam int unsigned OFS_HI_BASE = 32'hB0;

  function automatic int unsigned hi_ofs(input int unsigned ch);
    return OFS_HI_BASE + 4 * ch;
  endfunction

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned CH_IDX = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] cnt_i,
  input  logic          zero_i,
  output tmr_ctrl_t     ctrl_o,
  output tmr_ctrl_t     ctrl_nxt_o,
  output logic          start_o,
  output logic [DW-1:0] load_lo_o,
  output logic [DW-1:0] load_hi_o,
  output logic          raw_o,
  output logic          irq_o
);

  localparam logic [AW-1:0] A_LO   = AW'(OFS_LOAD_LO);
  localparam logic [AW-1:0] A_CUR  = AW'(OFS_CUR);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_EOI  = AW'(OFS_EOI);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_HI   = AW'(hi_ofs(CH_IDX));
  localparam int unsigned   NLOAD  = 2;

  tmr_ctrl_t ctrl_q, ctrl_d;
  logic      raw_q;
  logic      eoi_rd;

  // reload shadow registers: index 0 low phase, 1 high phase
  for (genvar g = 0; g < NLOAD; g++) begin : g_load
    localparam logic [AW-1:0] A_SEL = (g == 0) ? A_LO : A_HI;
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (wr_en_i && addr_i == A_SEL)  q <= wdata_i;
    end
  end

  assign load_lo_o = g_load[0].q;
  assign load_hi_o = g_load[1].q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i && addr_i == A_CTRL) ctrl_d = tmr_ctrl_t'(wdata_i[3:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign start_o    = ctrl_d.enable & ~ctrl_q.enable;
  assign ctrl_o     = ctrl_q;
  assign ctrl_nxt_o = ctrl_d;

  assign eoi_rd = rd_en_i && addr_i == A_EOI;

  // new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= 1'b0;
    else if (zero_i) raw_q <= 1'b1;
    else if (eoi_rd) raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & ~ctrl_q.irq_mask;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_LO)        rdata_o = g_load[0].q;
    else if (addr_i == A_CUR)  rdata_o = cnt_i;
    else if (addr_i == A_CTRL) rdata_o = DW'(ctrl_q);
    else if (addr_i == A_STAT) rdata_o = DW'(irq_o);
    else if (addr_i == A_HI)   rdata_o = g_load[1].q;
  end

endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          start_user_i,
  input  logic          run_i,
  input  logic          user_i,
  input  logic          pwm_i,
  input  logic [DW-1:0] load_lo_i,
  input  logic [DW-1:0] load_hi_i,
  output logic [DW-1:0] cnt_o,
  output logic          phase_o,
  output logic          zero_o
);

  logic [DW-1:0] cnt_q, act_lo_q, act_hi_q, reload;
  logic          phase_q, phase_nxt, at_zero;

  assign at_zero   = (cnt_q == '0);
  assign phase_nxt = pwm_i ? ~phase_q : 1'b0;

  always_comb begin
    if (!user_i)        reload = '1;
    else if (phase_nxt) reload = act_hi_q;
    else                reload = act_lo_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      act_lo_q <= '0;
      act_hi_q <= '0;
      phase_q  <= 1'b0;
    end else if (start_i) begin
      act_lo_q <= load_lo_i;
      act_hi_q <= load_hi_i;
      cnt_q    <= start_user_i ? load_lo_i : '1;
      phase_q  <= 1'b0;
    end else if (run_i) begin
      if (at_zero) begin
        cnt_q   <= reload;
        phase_q <= phase_nxt;
      end else begin
        cnt_q   <= cnt_q - 1'b1;
      end
    end else begin
      phase_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
  assign zero_o  = run_i & at_zero;

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned CH_IDX = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pwm_o,
  output logic          irq_o
);

  tmr_ctrl_t     ctrl_q, ctrl_nxt;
  logic          start, zero, phase, raw;
  logic [DW-1:0] cnt, load_lo, load_hi;
  logic          en_w, pwm_w, mask_w;

  pwm_timer_regs #(.DW(DW), .AW(AW), .CH_IDX(CH_IDX)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cnt_i      (cnt),
    .zero_i     (zero),
    .ctrl_o     (ctrl_q),
    .ctrl_nxt_o (ctrl_nxt),
    .start_o    (start),
    .load_lo_o  (load_lo),
    .load_hi_o  (load_hi),
    .raw_o      (raw),
    .irq_o      (irq_o)
  );

  pwm_timer_core #(.DW(DW)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_user_i (ctrl_nxt.user_mode),
    .run_i        (ctrl_q.enable),
    .user_i       (ctrl_q.user_mode),
    .pwm_i        (ctrl_q.pwm_on),
    .load_lo_i    (load_lo),
    .load_hi_i    (load_hi),
    .cnt_o        (cnt),
    .phase_o      (phase),
    .zero_o       (zero)
  );

  assign en_w   = ctrl_q.enable;
  assign pwm_w  = ctrl_q.pwm_on;
  assign mask_w = ctrl_q.irq_mask;
  assign pwm_o  = en_w & pwm_w & phase;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          pwm_mode_i,
  input logic          mask_i,
  input logic [DW-1:0] cnt_i,
  input logic          phase_i,
  input logic          raw_i,
  input logic          pwm_o,
  input logic          irq_o
);

  a_r5_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_o);

  a_r5_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> $stable(cnt_i));

  a_r4_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(cnt_i) != '0) |-> cnt_i == $past(cnt_i) - 1'b1);

  a_r1_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(pwm_mode_i) && $past(cnt_i) == '0)
      |-> phase_i != $past(phase_i));

  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !pwm_o);

  a_r8_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i == '0) |=> raw_i);

  a_r8_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_i && !mask_i));

endmodule

bind pwm_timer pwm_timer_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_w),
  .pwm_mode_i (pwm_w),
  .mask_i     (mask_w),
  .cnt_i      (cnt),
  .phase_i    (phase),
  .raw_i      (raw),
  .pwm_o      (pwm_o),
  .irq_o      (irq_o)
);

// File: tb/pwm_timer_test.sv
module pwm_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CH = 2;
  localparam logic [7:0] A_HI = 8'hB0 + 8'(4 * CH);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_timer #(.DW(32), .AW(8), .CH_IDX(CH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_lo, m_hi, m_alo, m_ahi, m_cnt;
  logic [3:0]  m_ctrl;
  logic        m_ph, m_raw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_alo = 0; m_ahi = 0; m_cnt = 0;
      m_ctrl = 0; m_ph = 0; m_raw = 0;
    end else begin
      logic [3:0] nc;
      logic ev;
      nc = m_ctrl;
      ev = 0;
      if (wr_en && addr == 8'h08) nc = wdata[3:0];
      if (nc[0] && !m_ctrl[0]) begin
        m_alo = m_lo; m_ahi = m_hi; m_ph = 0;
        m_cnt = nc[1] ? m_lo : 32'hFFFF_FFFF;
      end else if (m_ctrl[0]) begin
        if (m_cnt == 0) begin
          ev = 1;
          m_ph = m_ctrl[3] ? !m_ph : 1'b0;
          if (!m_ctrl[1]) m_cnt = 32'hFFFF_FFFF;
          else m_cnt = m_ph ? m_ahi : m_alo;
        end else m_cnt = m_cnt - 1;
      end else m_ph = 0;
      if (rd_en && addr == 8'h0C) m_raw = 0;
      if (ev) m_raw = 1;
      if (wr_en && addr == 8'h00) m_lo = wdata;
      if (wr_en && addr == A_HI) m_hi = wdata;
      m_ctrl = nc;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R1 pwm_o vs model", {31'd0, pwm_o}, {31'd0, m_ctrl[0] & m_ctrl[3] & m_ph});
    chk("R8 irq_o vs model", {31'd0, irq_o}, {31'd0, m_raw & ~m_ctrl[2]});
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (pwm_o === lvl && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_rise();
    int g = 0;
    while (pwm_o === 1'b1 && g < 100000) begin g++; @(negedge clk); end
    while (pwm_o === 1'b0 && g < 100000) begin g++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state (R7)
    chk("R7 reset pwm_o", {31'd0, pwm_o}, 0);
    chk("R8 reset irq_o", {31'd0, irq_o}, 0);
    rd(8'h08, d); chk("R7 reset ctrl", d, 0);
    rd(8'h04, d); chk("R7 reset count", d, 0);

    // R10 offset map
    wr(A_HI, 32'd9);     rd(A_HI, d);  chk("R10 high_load at B0+4n", d, 9);
    wr(8'hB0, 32'd77);   rd(8'hB0, d); chk("R10 unmapped reads 0", d, 0);
    rd(A_HI, d); chk("R10 unmapped write ignored", d, 9);

    // R6 free-running
    wr(8'h00, 32'd5);
    wr(8'h08, 32'h1);
    rd(8'h04, d); chk("R6 free start all-ones", d, 32'hFFFF_FFFE);
    // R5 hold while disabled
    wr(8'h08, 32'h0);
    rd(8'h04, d); repeat (4) @(negedge clk); rd(8'h04, d2);
    chk("R5 count holds when off", d2, d);
    chk("R5 pwm low when off", {31'd0, pwm_o}, 0);
    // R7 current count read-only
    wr(8'h04, 32'h55); rd(8'h04, d2); chk("R7 count ignores write", d2, d);

    // R4 user mode, PWM off
    wr(8'h00, 32'd2);
    wr(8'h08, 32'h3);
    rd(8'h04, d); chk("R4 first decrement", d, 1);
    repeat (7) @(negedge clk);
    chk("R4 pwm stays low without PWM bit", {31'd0, pwm_o}, 0);
    // R8 interrupt
    wr(8'h08, 32'h2);
    rd(8'h08, d); chk("R7 ctrl readback", d, 32'h2);
    rd(8'h10, d); chk("R8 status set", d, 1);
    rd(8'h0C, d); chk("R8 eoi reads 0", d, 0);
    rd(8'h10, d); chk("R8 status cleared by eoi", d, 0);
    wr(8'h08, 32'h7);
    repeat (8) @(negedge clk);
    chk("R8 masked irq_o low", {31'd0, irq_o}, 0);
    rd(8'h10, d); chk("R8 masked status", d, 0);
    wr(8'h08, 32'h3);
    chk("R8 unmask shows pending", {31'd0, irq_o}, 1);
    wr(8'h08, 32'h2);
    rd(8'h0C, d);

    // R1/R3 PWM widths
    wr(8'h00, 32'd3); wr(A_HI, 32'd5);
    wr(8'h08, 32'hB);
    run_len(0, n); chk("R3 first low phase", n, 4);
    run_len(1, n); chk("R1 high phase", n, 6);
    run_len(0, n); chk("R1 low phase", n, 4);
    // R9 writes during run are deferred
    wr(8'h00, 32'd7); wr(A_HI, 32'd1);
    wait_rise();
    run_len(1, n); chk("R9 high unchanged", n, 6);
    run_len(0, n); chk("R9 low unchanged", n, 4);
    wr(8'h08, 32'hA);
    chk("R5 pwm low after disable", {31'd0, pwm_o}, 0);
    wr(8'h08, 32'hB);
    run_len(0, n); chk("R9 new low after enable", n, 8);
    run_len(1, n); chk("R9 new high after enable", n, 2);

    // R2 zero loads
    wr(8'h08, 32'hA);
    wr(8'h00, 32'd0); wr(A_HI, 32'd0);
    wr(8'h08, 32'hB);
    run_len(0, n); chk("R2 one-clock low", n, 1);
    run_len(1, n); chk("R2 one-clock high", n, 1);
    run_len(0, n); chk("R2 one-clock low again", n, 1);
    wr(8'h08, 32'h0);
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule